// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block keeps the sticky floating-point status word of a processor core and decides when a floating-point hardware exception is taken. Each time the arithmetic unit completes an operation, it strobes a valid signal along with four raw condition flags: invalid operation, divide-by-zero, overflow and underflow. Each asserted flag is ORed into its own status bit. Hardware never clears these bits.

When an operation reports at least one condition, two enables decide whether a trap is taken. The first is a static configuration enable for floating-point exceptions. The second is the core's dynamic machine exception-enable bit. If both are set, the block loads a fixed floating-point cause code into the exception-status register and pulses an exception request for one cycle. The decision is made by a two-state machine. In RAISE_IDLE the request is low. In RAISE_FIRE the request is high. The transitions are:
- RAISE_IDLE goes to RAISE_FIRE, and RAISE_FIRE stays in RAISE_FIRE, when a strobe arrives with a qualifying flag and both enables set.
- Every other case returns to RAISE_IDLE or stays there.

Software has two ports. A write port stores only the low five bits of the written word. A read port returns the current status value, zero-extended. When a software write and a hardware update fall in the same cycle, the software write wins.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, the status reads 0, the exception-status register is 0 and the exception request is low.
- R2: On a cycle with the flag strobe high, each raised flag sets its status bit: invalid sets bit 4, divide-by-zero sets bit 3, overflow sets bit 2 and underflow sets bit 1. Hardware never clears a status bit.
- R3: Flags presented while the flag strobe is low change nothing.
- R4: The exception request is high in the cycle after a strobed operation in which at least one flag is set and both the configuration enable and the exception-enable bit are 1. It stays high for exactly that one cycle unless the next operation also qualifies.
- R5: No exception request follows an operation if the configuration enable is 0, the exception-enable bit is 0, or no flag is set.
- R6: When an exception request is raised, the exception-status register holds the cause code CAUSE_CODE (default 6). The register is unchanged at all other times.
- R7: A software write stores bits 4:0 of the written word and clears all higher bits. A read returns the status zero-extended to the port width.
- R8: A software write in the same cycle as a flag strobe sets the status to the written value. The exception decision for that operation is still made from its own flags.
- R9: The exception decision uses only the flags of the current operation. Status bits held over from earlier operations never cause a request.
- R10: Hardware never sets bit 0. Only a software write can set it.
- R11: Back-to-back qualifying operations produce a request in each following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_flag_valid | input | 1 | Strobe: an operation has completed and its flags are valid |
| op_flag_invalid | input | 1 | Invalid-operation flag |
| op_flag_divzero | input | 1 | Divide-by-zero flag |
| op_flag_overflow | input | 1 | Overflow flag |
| op_flag_underflow | input | 1 | Underflow flag |
| cfg_fpu_exc_en | input | 1 | Static configuration enable for floating-point exceptions |
| msr_exc_en | input | 1 | Dynamic machine exception-enable bit |
| sw_wr_en | input | 1 | Software write strobe for the status register |
| sw_wr_data | input | DATA_W | Software write data; only bits 4:0 are kept |
| sw_rd_data | output | DATA_W | Current status value, zero-extended |
| esr_q | output | ESR_W | Exception-status register |
| exc_req | output | 1 | One-cycle hardware exception request |

## Verification
Every result of this block arrives one clock edge after its stimulus. This covers the status bits, the software-read value, the exception-status register and the exception request, because each comes from a single register stage. The bench drives each stimulus vector just after a falling edge. It lets one rising edge pass and compares all outputs at the next falling edge. That sample point is the one cycle in which the request pulse is high. The vector that follows a raise checks that the pulse has dropped again.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    // Width of the architected status word.
    localparam int STAT_W  = 5;
    localparam int BIT_INV = 4;
    localparam int BIT_DZ  = 3;
    localparam int BIT_OVF = 2;
    localparam int BIT_UNF = 1;
    localparam int BIT_RSV = 0;

    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic unf;
    } fp_flags_t;

    typedef enum logic [0:0] {
        RAISE_IDLE = 1'b0,
        RAISE_FIRE = 1'b1
    } raise_state_t;

endpackage

// File: rtl/fpsc_sticky.sv
module fpsc_sticky
    import fpsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_valid,
    input  fp_flags_t         flags,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_bits,
    output logic [STAT_W-1:0] status
);

    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] status_d;

    always_comb begin
        hw_set          = '0;
        hw_set[BIT_INV] = flags.inv;
        hw_set[BIT_DZ]  = flags.dz;
        hw_set[BIT_OVF] = flags.ovf;
        hw_set[BIT_UNF] = flags.unf;
    end

    always_comb begin
        if (wr_en) begin
            status_d = wr_bits;
        end else if (flag_valid) begin
            status_d = status | hw_set;
        end else begin
            status_d = status;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_d;
        end
    end

    // Without a software write, no status bit falls.
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((status & $past(status)) == $past(status)));

    // Without a strobe or a write, the status holds.
    assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !flag_valid) |=> $stable(status));

    // The software write wins over a simultaneous flag update.
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status == $past(wr_bits)));

    // Bit 0 can only be set by a software write.
    assert_rsv_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !status[BIT_RSV]) |=> !status[BIT_RSV]);

endmodule

// File: rtl/fpsc_raise_fsm.sv
module fpsc_raise_fsm
    import fpsc_pkg::*;
#(
    parameter int              ESR_W      = 32,
    parameter logic [ESR_W-1:0] CAUSE_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_valid,
    input  fp_flags_t        flags,
    input  logic             cfg_exc_en,
    input  logic             msr_exc_en,
    output logic             exc_req,
    output logic [ESR_W-1:0] esr_q
);

    raise_state_t state_q;
    raise_state_t state_d;
    logic         qualify;

    // Only this operation's flags count.
    assign qualify = flag_valid && (|flags) && cfg_exc_en && msr_exc_en;

    always_comb begin
        unique case (state_q)
            RAISE_IDLE: state_d = qualify ? RAISE_FIRE : RAISE_IDLE;
            RAISE_FIRE: state_d = qualify ? RAISE_FIRE : RAISE_IDLE;
            default:    state_d = RAISE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RAISE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q <= '0;
        end else if (qualify) begin
            esr_q <= CAUSE_CODE;
        end
    end

    always_comb begin
        exc_req = (state_q == RAISE_FIRE);
    end

    assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_valid && (|flags) && cfg_exc_en && msr_exc_en) |=> exc_req);

    assert_no_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_valid && (|flags) && cfg_exc_en && msr_exc_en) |=> !exc_req);

    assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (esr_q == CAUSE_CODE));

    assert_esr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_valid && (|flags) && cfg_exc_en && msr_exc_en) |=> $stable(esr_q));

endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpsc_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               ESR_W      = 32,
    parameter logic [ESR_W-1:0] CAUSE_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_flag_valid,
    input  logic              op_flag_invalid,
    input  logic              op_flag_divzero,
    input  logic              op_flag_overflow,
    input  logic              op_flag_underflow,
    input  logic              cfg_fpu_exc_en,
    input  logic              msr_exc_en,
    input  logic              sw_wr_en,
    input  logic [DATA_W-1:0] sw_wr_data,
    output logic [DATA_W-1:0] sw_rd_data,
    output logic [ESR_W-1:0]  esr_q,
    output logic              exc_req
);

    localparam int PAD_W = DATA_W - STAT_W;

    fp_flags_t         flags;
    logic [STAT_W-1:0] status;

    assign flags = '{inv: op_flag_invalid, dz: op_flag_divzero,
                     ovf: op_flag_overflow, unf: op_flag_underflow};

    fpsc_sticky u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_valid (op_flag_valid),
        .flags      (flags),
        .wr_en      (sw_wr_en),
        .wr_bits    (sw_wr_data[STAT_W-1:0]),
        .status     (status)
    );

    fpsc_raise_fsm #(
        .ESR_W      (ESR_W),
        .CAUSE_CODE (CAUSE_CODE)
    ) u_raise (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_valid (op_flag_valid),
        .flags      (flags),
        .cfg_exc_en (cfg_fpu_exc_en),
        .msr_exc_en (msr_exc_en),
        .exc_req    (exc_req),
        .esr_q      (esr_q)
    );

    assign sw_rd_data = {{PAD_W{1'b0}}, status};

    // A written word reads back with its upper bits cleared.
    assert_wr_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (sw_rd_data == {{PAD_W{1'b0}}, $past(sw_wr_data[STAT_W-1:0])})
                     && ($past(sw_wr_data) == $past(sw_wr_data)));

    assert_rd_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd_data[DATA_W-1:STAT_W] == '0);

endmodule

// File: tb/fp_status_ctrl_bench.sv
`timescale 1ns/1ps
module fp_status_ctrl_bench;

    localparam int          DW    = 32;
    localparam int          EW    = 32;
    localparam logic [31:0] CAUSE = 32'd6;
    localparam int          NV    = 12;

    // Row layout: wr_en, wdata[4:0], valid, inv, dz, ovf, unf, cfg, ee,
    // expected status[4:0], expected request.
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 5'd0,     1'b1, 4'b0001, 1'b1, 1'b0, 5'b00010, 1'b0}, // R2 R5 ee off
        {1'b0, 5'd0,     1'b1, 4'b0010, 1'b0, 1'b1, 5'b00110, 1'b0}, // R2 R5 cfg off
        {1'b0, 5'd0,     1'b0, 4'b1000, 1'b1, 1'b1, 5'b00110, 1'b0}, // R3
        {1'b0, 5'd0,     1'b1, 4'b0000, 1'b1, 1'b1, 5'b00110, 1'b0}, // R9
        {1'b0, 5'd0,     1'b1, 4'b0100, 1'b1, 1'b1, 5'b01110, 1'b1}, // R4 R6
        {1'b0, 5'd0,     1'b1, 4'b1000, 1'b1, 1'b1, 5'b11110, 1'b1}, // R11
        {1'b0, 5'd0,     1'b0, 4'b0000, 1'b1, 1'b1, 5'b11110, 1'b0}, // R4 pulse ends
        {1'b1, 5'b00001, 1'b0, 4'b0000, 1'b0, 1'b0, 5'b00001, 1'b0}, // R7 R10
        {1'b1, 5'b00000, 1'b1, 4'b1000, 1'b1, 1'b1, 5'b00000, 1'b1}, // R8
        {1'b0, 5'd0,     1'b1, 4'b0011, 1'b1, 1'b1, 5'b00110, 1'b1}, // R2 R4
        {1'b0, 5'd0,     1'b1, 4'b1111, 1'b0, 1'b0, 5'b11110, 1'b0}, // R5 R10
        {1'b1, 5'b00000, 1'b0, 4'b0000, 1'b0, 1'b0, 5'b00000, 1'b0}  // R7
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_flag_valid, op_flag_invalid, op_flag_divzero;
    logic          op_flag_overflow, op_flag_underflow;
    logic          cfg_fpu_exc_en, msr_exc_en, sw_wr_en;
    logic [DW-1:0] sw_wr_data, sw_rd_data;
    logic [EW-1:0] esr_q;
    logic          exc_req;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [31:0] exp_esr;

    always #2.5 clk = ~clk;

    fp_status_ctrl #(.DATA_W(DW), .ESR_W(EW), .CAUSE_CODE(CAUSE)) u_fp_status_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_flag_valid(op_flag_valid), .op_flag_invalid(op_flag_invalid),
        .op_flag_divzero(op_flag_divzero), .op_flag_overflow(op_flag_overflow),
        .op_flag_underflow(op_flag_underflow), .cfg_fpu_exc_en(cfg_fpu_exc_en),
        .msr_exc_en(msr_exc_en), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_rd_data(sw_rd_data), .esr_q(esr_q), .exc_req(exc_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_flag_valid = 0; op_flag_invalid = 0; op_flag_divzero = 0;
        op_flag_overflow = 0; op_flag_underflow = 0;
        cfg_fpu_exc_en = 0; msr_exc_en = 0; sw_wr_en = 0; sw_wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        check("R1 status", sw_rd_data, 32'd0);
        check("R1 esr", esr_q, 32'd0);
        check("R1 req", {31'd0, exc_req}, 32'd0);
        exp_esr = 32'd0;

        for (int i = 0; i < NV; i++) begin
            sw_wr_en          = VEC[i][18];
            sw_wr_data        = {27'h7ffffff, VEC[i][17:13]};
            op_flag_valid     = VEC[i][12];
            op_flag_invalid   = VEC[i][11];
            op_flag_divzero   = VEC[i][10];
            op_flag_overflow  = VEC[i][9];
            op_flag_underflow = VEC[i][8];
            cfg_fpu_exc_en    = VEC[i][7];
            msr_exc_en        = VEC[i][6];
            step();
            if (VEC[i][0]) exp_esr = CAUSE;
            check($sformatf("R2/R7/R8 status row %0d", i), sw_rd_data, {27'd0, VEC[i][5:1]});
            check($sformatf("R4/R5/R11 req row %0d", i), {31'd0, exc_req}, {31'd0, VEC[i][0]});
            check($sformatf("R6 esr row %0d", i), esr_q, exp_esr);
            idle_inputs();
        end

        // R10 all flags, no write: bit 0 stays clear
        op_flag_valid = 1; op_flag_invalid = 1; op_flag_divzero = 1;
        op_flag_overflow = 1; op_flag_underflow = 1;
        step();
        idle_inputs();
        check("R10 bit0 clear", {31'd0, sw_rd_data[0]}, 32'd0);

        // R7 upper bits dropped
        sw_wr_en = 1; sw_wr_data = 32'hFFFF_FFF5;
        step();
        idle_inputs();
        check("R7 masked write", sw_rd_data, 32'h0000_0015);
        step();
        check("R3 hold after write", sw_rd_data, 32'h0000_0015);

        // R1 reset mid-run
        rst_n = 0;
        step();
        rst_n = 1;
        check("R1 status after reset", sw_rd_data, 32'd0);
        check("R1 esr after reset", esr_q, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule